// File: doc/BRIEF.md
# Variable Byte Blend Execution Unit

This unit executes a packed-byte conditional select against a private vector register file of sixteen 256-bit registers. Each decoded instruction names an encoding form, a destination, two source registers, an 8-bit immediate, a W bit and an operating-mode flag. The unit reads every operand in the issue cycle and forms each result byte from one of two sources. The choice is made by the top bit of the matching byte of a mask register. The result is written back, and the upper 128 bits are handled according to the form. Illegal encodings raise a one-cycle fault pulse in place of the write.

Three form codes are legal. Code 0 is the legacy 128-bit form, which is destructive and always takes its mask from register 0. Code 1 is the VEX 128-bit form, which is non-destructive and zeroes the upper half. Code 2 is the VEX 256-bit form, which blends all 32 bytes. Code 3 is reserved. A test load port writes whole registers. A combinational test read port exposes any register. Together they let a bench preset and inspect state.

Top module: `vblend_unit`

## Requirements
- R1: Result byte i is the second-source byte when bit 8*i+7 of the mask register is 1, and the first-source byte otherwise. The other seven bits of each mask byte have no effect.
- R2: In form 0, the destination register is also the first source and the mask is always register 0. The src1 field, the immediate and the W bit are ignored, and form 0 never raises a fault because of them.
- R3: In form 0, bits 255:128 of the destination keep their previous value.
- R4: In form 1, the first source is the register named by the src1 field. Destination bits 255:128 are written as zero.
- R5: In forms 1 and 2, the mask register index is immediate bits 7:4, and immediate bits 3:0 have no effect.
- R6: When the 32-bit mode flag is 1, immediate bit 7 is treated as 0 when the mask index is formed, so only registers 0 to 7 serve as a mask.
- R7: Form 2 blends all 32 bytes under R1.
- R8: A form 1 or form 2 issue with the W bit set raises a fault and writes no register.
- R9: When the 32-bit mode flag is 1, a destination or src2 index of 8 or more raises a fault and writes no register. In forms 1 and 2 the same applies to a src1 index of 8 or more.
- R10: Form code 3 raises a fault and writes no register.
- R11: A legal issue on clock edge k updates the destination at edge k, and done is 1 for exactly the cycle after edge k. A faulting issue instead makes fault 1 for that cycle. Done and fault are never 1 together, and back-to-back issues are accepted every cycle.
- R12: All operands are read before the write, so a destination that is also a source or the mask yields the blend of the old values. A back-to-back issue sees the previous result.
- R13: Reset clears all registers, done and fault. A load strobe with no issue in the same cycle writes loadData into register loadIdx at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue strobe, sampled on the rising edge |
| issueForm | input | 2 | Form code: 0 legacy 128-bit, 1 VEX 128-bit, 2 VEX 256-bit, 3 reserved |
| issueDst | input | 4 | Destination register index |
| issueSrc1 | input | 4 | First source index (unused in form 0) |
| issueSrc2 | input | 4 | Second source index |
| issueImm | input | 8 | Immediate; bits 7:4 select the mask in forms 1 and 2 |
| issueWBit | input | 1 | W bit of the encoding |
| issueMode32 | input | 1 | 32-bit operating mode flag |
| loadEn | input | 1 | Test load strobe |
| loadIdx | input | 4 | Test load register index |
| loadData | input | 256 | Test load data |
| readIdx | input | 4 | Test read register index |
| readData | output | 256 | Test read data, combinational |
| doneOut | output | 1 | One-cycle pulse after a legal issue |
| faultOut | output | 1 | One-cycle undefined-opcode pulse after an illegal issue |

## Verification
A legal or faulting issue sampled on a rising edge has its effect due in the low phase that follows that edge. In that phase the register file already holds the result, and exactly one of done or fault is high. The bench keeps its own register array and expected pulse bits, and updates them on the same edge from the inputs it drove. It compares done and fault against them at every falling edge. After each group of operations it sweeps all sixteen registers through the combinational read port between two rising edges.

// File: rtl/vblend_pkg.sv
package vblend_pkg;

  typedef enum logic [1:0] {
    FORM_LEGACY = 2'd0,
    FORM_VEX128 = 2'd1,
    FORM_VEX256 = 2'd2,
    FORM_RSVD   = 2'd3
  } blendForm_e;

  typedef enum logic [1:0] {
    UPPER_BLEND = 2'd0,
    UPPER_ZERO  = 2'd1,
    UPPER_KEEP  = 2'd2
  } upperMode_e;

  // Strobes from control to datapath for the current issue cycle.
  typedef struct packed {
    logic       wrEn;
    upperMode_e upperMode;
  } ctrlStrobe_t;

endpackage

// File: rtl/vblend_regfile.sv
module vblend_regfile #(
  parameter int NumRegs = 16,
  parameter int RegBits = 256,
  localparam int IdxW = $clog2(NumRegs)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IdxW-1:0]    rdIdxA,
  input  logic [IdxW-1:0]    rdIdxB,
  input  logic [IdxW-1:0]    rdIdxM,
  input  logic [IdxW-1:0]    rdIdxT,
  output logic [RegBits-1:0] rdDataA,
  output logic [RegBits-1:0] rdDataB,
  output logic [RegBits-1:0] rdDataM,
  output logic [RegBits-1:0] rdDataT,
  input  logic               wrEn,
  input  logic [IdxW-1:0]    wrIdx,
  input  logic [RegBits-1:0] wrData,
  input  logic               ldEn,
  input  logic [IdxW-1:0]    ldIdx,
  input  logic [RegBits-1:0] ldData
);

  logic [RegBits-1:0] regArr [NumRegs];

  for (genvar g = 0; g < NumRegs; g++) begin : gRegs
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regArr[g] <= '0;
      end else if (wrEn && (wrIdx == IdxW'(g))) begin
        regArr[g] <= wrData;
      end else if (!wrEn && ldEn && (ldIdx == IdxW'(g))) begin
        regArr[g] <= ldData;
      end
    end
  end

  assign rdDataA = regArr[rdIdxA];
  assign rdDataB = regArr[rdIdxB];
  assign rdDataM = regArr[rdIdxM];
  assign rdDataT = regArr[rdIdxT];

endmodule

// File: rtl/vblend_ctrl.sv
module vblend_ctrl
  import vblend_pkg::*;
#(
  parameter int NumRegs = 16,
  localparam int IdxW = $clog2(NumRegs)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic [1:0]      issueForm,
  input  logic [IdxW-1:0] issueDst,
  input  logic [IdxW-1:0] issueSrc1,
  input  logic [IdxW-1:0] issueSrc2,
  input  logic [7:0]      issueImm,
  input  logic            issueWBit,
  input  logic            issueMode32,
  output ctrlStrobe_t     strobe,
  output logic [IdxW-1:0] src1Idx,
  output logic [IdxW-1:0] src2Idx,
  output logic [IdxW-1:0] maskIdx,
  output logic [IdxW-1:0] dstIdx,
  output logic            doneOut,
  output logic            faultOut
);

  blendForm_e form;
  logic       isVex;
  logic       badForm;
  logic       badW;
  logic       badIdx;
  logic       anyFault;
  logic [3:0] maskField;
  logic [3:0] unusedImmLow;

  assign form         = blendForm_e'(issueForm);
  assign isVex        = (form == FORM_VEX128) || (form == FORM_VEX256);
  assign unusedImmLow = issueImm[3:0];

  // Mask index: fixed register 0 in legacy form, immediate high nibble otherwise.
  always_comb begin
    maskField = issueImm[7:4];
    if (issueMode32) maskField[3] = 1'b0;
  end

  assign maskIdx = isVex ? IdxW'(maskField) : '0;
  assign src1Idx = isVex ? issueSrc1 : issueDst;
  assign src2Idx = issueSrc2;
  assign dstIdx  = issueDst;

  // Legality checks.
  assign badForm  = (form == FORM_RSVD);
  assign badW     = isVex && issueWBit;
  assign badIdx   = issueMode32 &&
                    (issueDst[IdxW-1] || issueSrc2[IdxW-1] ||
                     (isVex && issueSrc1[IdxW-1]));
  assign anyFault = badForm || badW || badIdx;

  always_comb begin
    strobe.wrEn = issueValid && !anyFault;
    unique case (form)
      FORM_LEGACY: strobe.upperMode = UPPER_KEEP;
      FORM_VEX128: strobe.upperMode = UPPER_ZERO;
      default:     strobe.upperMode = UPPER_BLEND;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneOut  <= 1'b0;
      faultOut <= 1'b0;
    end else begin
      doneOut  <= issueValid && !anyFault;
      faultOut <= issueValid && anyFault;
    end
  end

  AST_VEXW_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueWBit && (issueForm == 2'd1 || issueForm == 2'd2))
      |=> (faultOut && !doneOut)); // R8

  AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueForm == 2'd3) |=> faultOut); // R10

  AST_HIGH_DST_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueMode32 && issueDst[IdxW-1]) |=> faultOut); // R9

  AST_PULSE_HAS_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut || faultOut) |-> $past(issueValid)); // R11

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && faultOut)); // R11

  AST_MODE32_MASK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueMode32) |-> !maskIdx[IdxW-1]); // R6

  AST_LEGACY_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueForm == 2'd0) |-> (maskIdx == '0 && !faultOutNext())); // R2

  function automatic logic faultOutNext();
    return anyFault && !badIdx;
  endfunction

endmodule

// File: rtl/vblend_datapath.sv
module vblend_datapath
  import vblend_pkg::*;
#(
  parameter int RegBits  = 256,
  parameter int LaneBits = 128,
  localparam int NumBytes = RegBits / 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [RegBits-1:0] src1Data,
  input  logic [RegBits-1:0] src2Data,
  input  logic [RegBits-1:0] maskData,
  output logic [RegBits-1:0] wrData
);

  logic [RegBits-1:0]  blended;
  logic [NumBytes-1:0] selBits;
  logic [RegBits-1:0]  unusedMaskBits;

  assign unusedMaskBits = maskData;

  // One byte selector per byte position, steered by the byte's top bit.
  for (genvar b = 0; b < NumBytes; b++) begin : gByte
    assign selBits[b] = maskData[8*b + 7];
    assign blended[8*b +: 8] = selBits[b] ? src2Data[8*b +: 8] : src1Data[8*b +: 8];
  end

  assign wrData[LaneBits-1:0] = blended[LaneBits-1:0];

  always_comb begin
    unique case (strobe.upperMode)
      UPPER_ZERO: wrData[RegBits-1:LaneBits] = '0;
      UPPER_KEEP: wrData[RegBits-1:LaneBits] = src1Data[RegBits-1:LaneBits];
      default:    wrData[RegBits-1:LaneBits] = blended[RegBits-1:LaneBits];
    endcase
  end

  AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.upperMode == UPPER_ZERO)
      |-> (wrData[RegBits-1:LaneBits] == '0)); // R4

endmodule

// File: rtl/vblend_unit.sv
module vblend_unit
  import vblend_pkg::*;
#(
  parameter int NumRegs  = 16,
  parameter int RegBits  = 256,
  parameter int LaneBits = 128,
  localparam int IdxW = $clog2(NumRegs)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [1:0]         issueForm,
  input  logic [IdxW-1:0]    issueDst,
  input  logic [IdxW-1:0]    issueSrc1,
  input  logic [IdxW-1:0]    issueSrc2,
  input  logic [7:0]         issueImm,
  input  logic               issueWBit,
  input  logic               issueMode32,
  input  logic               loadEn,
  input  logic [IdxW-1:0]    loadIdx,
  input  logic [RegBits-1:0] loadData,
  input  logic [IdxW-1:0]    readIdx,
  output logic [RegBits-1:0] readData,
  output logic               doneOut,
  output logic               faultOut
);

  ctrlStrobe_t        strobe;
  logic [IdxW-1:0]    src1Idx;
  logic [IdxW-1:0]    src2Idx;
  logic [IdxW-1:0]    maskIdx;
  logic [IdxW-1:0]    dstIdx;
  logic [RegBits-1:0] src1Data;
  logic [RegBits-1:0] src2Data;
  logic [RegBits-1:0] maskData;
  logic [RegBits-1:0] wrData;

  vblend_ctrl #(.NumRegs(NumRegs)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueForm  (issueForm),
    .issueDst   (issueDst),
    .issueSrc1  (issueSrc1),
    .issueSrc2  (issueSrc2),
    .issueImm   (issueImm),
    .issueWBit  (issueWBit),
    .issueMode32(issueMode32),
    .strobe     (strobe),
    .src1Idx    (src1Idx),
    .src2Idx    (src2Idx),
    .maskIdx    (maskIdx),
    .dstIdx     (dstIdx),
    .doneOut    (doneOut),
    .faultOut   (faultOut)
  );

  vblend_regfile #(.NumRegs(NumRegs), .RegBits(RegBits)) rf_i (
    .clk    (clk),
    .rstN   (rstN),
    .rdIdxA (src1Idx),
    .rdIdxB (src2Idx),
    .rdIdxM (maskIdx),
    .rdIdxT (readIdx),
    .rdDataA(src1Data),
    .rdDataB(src2Data),
    .rdDataM(maskData),
    .rdDataT(readData),
    .wrEn   (strobe.wrEn),
    .wrIdx  (dstIdx),
    .wrData (wrData),
    .ldEn   (loadEn),
    .ldIdx  (loadIdx),
    .ldData (loadData)
  );

  vblend_datapath #(.RegBits(RegBits), .LaneBits(LaneBits)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .src1Data(src1Data),
    .src2Data(src2Data),
    .maskData(maskData),
    .wrData  (wrData)
  );

endmodule

// File: tb/vblend_unit_tb_top.sv
`timescale 1ns/1ps
module vblend_unit_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         issueValid = 1'b0;
  logic [1:0]   issueForm = '0;
  logic [3:0]   issueDst = '0;
  logic [3:0]   issueSrc1 = '0;
  logic [3:0]   issueSrc2 = '0;
  logic [7:0]   issueImm = '0;
  logic         issueWBit = 1'b0;
  logic         issueMode32 = 1'b0;
  logic         loadEn = 1'b0;
  logic [3:0]   loadIdx = '0;
  logic [255:0] loadData = '0;
  logic [3:0]   readIdx = '0;
  logic [255:0] readData;
  logic         doneOut;
  logic         faultOut;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  logic [255:0] model [16];
  logic         expDone = 1'b0;
  logic         expFault = 1'b0;

  always #2.5 clk = ~clk;

  vblend_unit dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueForm(issueForm),
    .issueDst(issueDst), .issueSrc1(issueSrc1), .issueSrc2(issueSrc2),
    .issueImm(issueImm), .issueWBit(issueWBit), .issueMode32(issueMode32),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .readIdx(readIdx), .readData(readData), .doneOut(doneOut), .faultOut(faultOut)
  );

  // Reference: legality of an encoding.
  function automatic bit refFault(logic [1:0] f, logic w, logic m32,
                                  logic [3:0] d, logic [3:0] s1, logic [3:0] s2);
    if (f == 2'd3) return 1'b1;
    if (f != 2'd0 && w) return 1'b1;
    if (m32 && (d >= 8 || s2 >= 8)) return 1'b1;
    if (m32 && f != 2'd0 && s1 >= 8) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int refMask(logic [1:0] f, logic m32, logic [7:0] imm);
    int idx;
    if (f == 2'd0) return 0;
    idx = int'(imm) / 16;
    if (m32 && idx >= 8) idx = idx - 8;
    return idx;
  endfunction

  function automatic logic [255:0] refBlend(logic [1:0] f, logic [255:0] a,
                                           logic [255:0] b, logic [255:0] m);
    logic [255:0] r;
    for (int i = 0; i < 32; i++) begin
      if (i < 16 || f == 2'd2) r[8*i +: 8] = m[8*i+7] ? b[8*i +: 8] : a[8*i +: 8];
      else if (f == 2'd1)      r[8*i +: 8] = 8'h00;
      else                     r[8*i +: 8] = a[8*i +: 8];
    end
    return r;
  endfunction

  // Cycle model, advanced on the same edge as the design.
  always @(posedge clk) begin
    if (!rstN) begin
      expDone  <= 1'b0;
      expFault <= 1'b0;
      for (int i = 0; i < 16; i++) model[i] <= '0;
    end else begin
      expDone  <= 1'b0;
      expFault <= 1'b0;
      if (issueValid) begin
        if (refFault(issueForm, issueWBit, issueMode32, issueDst, issueSrc1, issueSrc2)) begin
          expFault <= 1'b1;
        end else begin
          expDone <= 1'b1;
          model[issueDst] <= refBlend(issueForm,
            (issueForm == 2'd0) ? model[issueDst] : model[issueSrc1],
            model[issueSrc2], model[refMask(issueForm, issueMode32, issueImm)]);
        end
      end else if (loadEn) begin
        model[loadIdx] <= loadData;
      end
    end
  end

  task automatic check1(string tag, logic [255:0] act, logic [255:0] exp, string what);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Pulse comparison on every clock (R11).
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check1("R11", {255'd0, doneOut}, {255'd0, expDone}, "done pulse");
      check1("R11", {255'd0, faultOut}, {255'd0, expFault}, "fault pulse");
    end
  end

  task automatic checkRegs(string tag);
    for (int i = 0; i < 16; i++) begin
      readIdx = 4'(i);
      #0.1;
      check1(tag, readData, model[i], $sformatf("reg %0d", i));
    end
  endtask

  task automatic issueOp(logic [1:0] f, logic [3:0] d, logic [3:0] s1, logic [3:0] s2,
                         logic [7:0] imm, logic w, logic m32);
    @(negedge clk);
    issueValid = 1'b1; issueForm = f; issueDst = d; issueSrc1 = s1;
    issueSrc2 = s2; issueImm = imm; issueWBit = w; issueMode32 = m32;
  endtask

  task automatic endOps();
    @(negedge clk);
    issueValid = 1'b0; issueWBit = 1'b0; issueMode32 = 1'b0;
  endtask

  task automatic loadReg(logic [3:0] idx, logic [255:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = idx; loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [255:0] alt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R13: reset state
    check1("R13", {255'd0, doneOut}, 256'd0, "done after reset");
    check1("R13", {255'd0, faultOut}, 256'd0, "fault after reset");
    checkRegs("R13");

    // R13: load port presets every register
    for (int i = 0; i < 16; i++) loadReg(4'(i), rnd256());
    for (int k = 0; k < 32; k++) alt[8*k +: 8] = k[0] ? 8'h80 : 8'h7F;
    loadReg(4'd3, alt);
    checkRegs("R13");

    // R1 R7: 256-bit blend, mask bytes 0x7F/0x80 show only the top bit counts
    issueOp(2'd2, 4'd1, 4'd2, 4'd4, 8'h30, 1'b0, 1'b0);
    endOps();
    checkRegs("R7");
    issueOp(2'd2, 4'd6, 4'd8, 4'd9, 8'hA0, 1'b0, 1'b0);
    endOps();
    checkRegs("R1");

    // R4 R5: VEX 128 with nonzero immediate low bits, upper zeroed
    issueOp(2'd1, 4'd6, 4'd7, 4'd8, 8'h3A, 1'b0, 1'b0);
    endOps();
    checkRegs("R4");
    issueOp(2'd2, 4'd9, 4'd10, 4'd11, 8'h5F, 1'b0, 1'b0);
    endOps();
    checkRegs("R5");

    // R2 R3: legacy form ignores src1, immediate and W; upper half kept
    issueOp(2'd0, 4'd12, 4'd13, 4'd14, 8'hF0, 1'b1, 1'b0);
    endOps();
    checkRegs("R3");
    issueOp(2'd0, 4'd2, 4'd15, 4'd3, 8'h00, 1'b0, 1'b1);
    endOps();
    checkRegs("R2");

    // R6: 32-bit mode drops immediate bit 7 (imm D0 -> mask register 5)
    issueOp(2'd2, 4'd1, 4'd2, 4'd3, 8'hD0, 1'b0, 1'b1);
    endOps();
    checkRegs("R6");

    // R8: W bit set in VEX forms
    issueOp(2'd1, 4'd4, 4'd5, 4'd6, 8'h10, 1'b1, 1'b0);
    issueOp(2'd2, 4'd5, 4'd5, 4'd6, 8'h10, 1'b1, 1'b0);
    endOps();
    checkRegs("R8");

    // R9: high indices in 32-bit mode
    issueOp(2'd1, 4'd9, 4'd1, 4'd2, 8'h00, 1'b0, 1'b1);
    issueOp(2'd0, 4'd1, 4'd1, 4'd12, 8'h00, 1'b0, 1'b1);
    issueOp(2'd2, 4'd1, 4'd14, 4'd2, 8'h00, 1'b0, 1'b1);
    endOps();
    checkRegs("R9");

    // R10: reserved form code
    issueOp(2'd3, 4'd1, 4'd2, 4'd3, 8'h40, 1'b0, 1'b0);
    endOps();
    checkRegs("R10");

    // R12: overlap of destination with sources and mask
    issueOp(2'd2, 4'd5, 4'd5, 4'd6, 8'h50, 1'b0, 1'b0);
    endOps();
    checkRegs("R12");
    issueOp(2'd0, 4'd0, 4'd0, 4'd0, 8'h00, 1'b0, 1'b0);
    endOps();
    checkRegs("R12");

    // R11 R12: back-to-back issues, fault between two writes
    issueOp(2'd2, 4'd7, 4'd1, 4'd2, 8'h30, 1'b0, 1'b0);
    issueOp(2'd1, 4'd8, 4'd7, 4'd7, 8'h70, 1'b0, 1'b0);
    issueOp(2'd3, 4'd8, 4'd0, 4'd0, 8'h00, 1'b0, 1'b0);
    issueOp(2'd2, 4'd10, 4'd8, 4'd7, 8'h80, 1'b0, 1'b0);
    endOps();
    checkRegs("R11");

    // R13: load while an issue is present is not applied (issue wins)
    @(negedge clk);
    loadEn = 1'b1; loadIdx = 4'd11; loadData = rnd256();
    issueValid = 1'b1; issueForm = 2'd2; issueDst = 4'd12; issueSrc1 = 4'd1;
    issueSrc2 = 4'd2; issueImm = 8'h30;
    @(negedge clk);
    loadEn = 1'b0; issueValid = 1'b0;
    checkRegs("R13");

    repeat (2) @(negedge clk);
    finish();
  end

endmodule